// File: doc/BRIEF.md
# Conditional Skip and Instruction-Length Unit

This unit settles the outcome of a conditional-test instruction in a small 16-bit processor. Each test compares two operand values that were fetched earlier. A passing test lets execution fall through to the next instruction, so the program counter is left unchanged. A failing test skips the whole next instruction, including any extra operand words that follow it.

The length of the skipped instruction is not fixed. When a skip is needed, the unit reads the instruction word that sits at the current PC through a single-word read port. It decodes the two operand fields of that word to count the extra words, then adds one to three to the PC. When the new PC is ready, the unit raises a one-cycle done strobe. The sequencer starts the unit with a start pulse and takes the new PC from `pc_out` in the cycle where `done` is high.

Top module: `cond_skip_unit`

## Requirements
- R1: With `cond_op` = 0 (equal test), the PC stays the same when `opnd_a` == `opnd_b`, and a skip happens when they differ.
- R2: With `cond_op` = 1 (not-equal test), the PC stays the same when the operands differ, and a skip happens when they are equal.
- R3: With `cond_op` = 2 (greater test), the PC stays the same when `opnd_a` > `opnd_b` as unsigned values, and a skip happens when `opnd_a` <= `opnd_b`.
- R4: With `cond_op` = 3 (bit test), the PC stays the same when `opnd_a & opnd_b` is nonzero, and a skip happens when it is zero.
- R5: A skip adds 1 + e(a) + e(b) to the PC. Here e(x) is 1 when the 6-bit operand code x is in the range 0x10..0x17 or is 0x1E or 0x1F, and 0 for any other code. The first operand code sits in bits 9:4 of the fetched word and the second in bits 15:10. For example, word 0x7C02 at PC 0 gives a new PC of 2.
- R6: The PC addition wraps modulo 2^16.
- R7: On a skip, `mem_rd` is high for exactly the cycle after start was accepted, with `mem_addr` equal to the start PC. The memory returns `mem_rdata` in the following cycle, and `done` rises two cycles after `mem_rd`.
- R8: When no skip is needed, `done` is high in the cycle right after start was accepted, `pc_out` equals the start PC, and no read is issued.
- R9: `done` lasts one cycle. A `start` pulse that arrives while the unit is busy is ignored and does not change the result.
- R10: After reset, `done` and `mem_rd` are low and `pc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluation (accepted only when idle) |
| cond_op | input | 2 | Test kind: 0 equal, 1 not-equal, 2 greater, 3 bit test |
| opnd_a | input | 16 | First operand value |
| opnd_b | input | 16 | Second operand value |
| pc_in | input | 16 | PC pointing at the following instruction |
| mem_rdata | input | 16 | Word returned one cycle after `mem_rd` |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| pc_out | output | 16 | Resulting PC, valid while `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
A wrong test decision makes the unit take the wrong path. The error then shows at the ports in the first cycle after start, because `mem_rd` or `done` rises when the other should. A wrong length decode or a wrong state sequence can only be seen at `done`, three cycles after start. At that point `pc_out` is off by one or two, or the strobe arrives early, late or twice. For this reason the bench checks the latency and the value of every operation. It also checks the address of every read request.

// File: rtl/cond_skip_unit.sv
module cond_skip_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   cond_op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_rd,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] pc_out,
  output logic         done
);

  localparam int FLD_W = 6;
  localparam int A_LO  = 4;
  localparam int B_LO  = A_LO + FLD_W;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_UPD, S_DONE} state_t;

  state_t       state;
  logic [W-1:0] pc_r;
  logic         skip;
  logic [W-1:0] step;

  function automatic logic extra_word(input logic [FLD_W-1:0] code);
    return (code[5:3] == 3'b010) || (code[5:1] == 5'b01111);
  endfunction

  always_comb begin
    case (cond_op)
      2'd0:    skip = (opnd_a != opnd_b);
      2'd1:    skip = (opnd_a == opnd_b);
      2'd2:    skip = !(opnd_a > opnd_b);
      default: skip = ((opnd_a & opnd_b) == '0);
    endcase
  end

  assign step = W'(1)
              + W'(extra_word(mem_rdata[A_LO +: FLD_W]))
              + W'(extra_word(mem_rdata[B_LO +: FLD_W]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc_r  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pc_r  <= pc_in;
          state <= skip ? S_READ : S_DONE;
        end
        S_READ: state <= S_UPD;
        S_UPD: begin
          pc_r  <= pc_r + step;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd   = (state == S_READ);
  assign mem_addr = pc_r;
  assign pc_out   = pc_r;
  assign done     = (state == S_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!done && !mem_rd) ##1 done); // R7
  AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UPD) |=> ((W'(pc_out - $past(pc_out)) >= W'(1)) && (W'(pc_out - $past(pc_out)) <= W'(3)))); // R5
  AST_GT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && cond_op == 2'd2 && opnd_a > opnd_b) |=> (done && pc_out == $past(pc_in))); // R3
  AST_BIT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && cond_op == 2'd3 && (opnd_a & opnd_b) == '0) |=> (mem_rd && mem_addr == $past(pc_in))); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ) |=> $stable(pc_out)); // R9

endmodule

// File: tb/cond_skip_unit_tb.sv
module cond_skip_unit_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [1:0]  cond_op = 0;
  logic [15:0] opnd_a = 0, opnd_b = 0, pc_in = 0, mem_rdata = 0;
  logic        mem_rd, done;
  logic [15:0] mem_addr, pc_out;
  logic [15:0] mem_word = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cond_skip_unit dut_i (.clk(clk), .rst_n(rst_n), .start(start), .cond_op(cond_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pc_in(pc_in), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .pc_out(pc_out), .done(done));

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_word;

  function automatic bit exp_skip(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      2'd0: return a != b;
      2'd1: return a == b;
      2'd2: return a <= b;
      default: return (a & b) == 0;
    endcase
  endfunction

  function automatic int ext(input logic [5:0] c);
    return ((c >= 6'h10 && c <= 6'h17) || c == 6'h1E || c == 6'h1F) ? 1 : 0;
  endfunction

  function automatic logic [15:0] exp_pc(input logic [1:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] pc, input logic [15:0] w);
    if (!exp_skip(op, a, b)) return pc;
    return 16'(pc + 16'(1 + ext(w[9:4]) + ext(w[15:10])));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] pc, input logic [15:0] w, input bit poke);
    int lat;
    bit sk;
    sk = exp_skip(op, a, b);
    @(negedge clk);
    cond_op = op; opnd_a = a; opnd_b = b; pc_in = pc; mem_word = w; start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    if (sk) begin
      check({req, " R7 mem_rd"}, {31'd0, mem_rd}, 1);
      check({req, " R7 mem_addr"}, {16'd0, mem_addr}, {16'd0, pc});
      if (poke) begin
        start = 1; pc_in = ~pc; cond_op = 2'd2; opnd_a = 16'hFFFF; opnd_b = 0;
      end
    end else begin
      check({req, " R8 no read"}, {31'd0, mem_rd}, 0);
    end
    while (!done && lat < 10) begin
      @(negedge clk);
      start = 0;
      lat++;
    end
    check({req, " latency R7/R8"}, lat, sk ? 3 : 1);
    check({req, " pc_out"}, {16'd0, pc_out}, {16'd0, exp_pc(op, a, b, pc, w)});
    @(negedge clk);
    check({req, " R9 done pulse"}, {31'd0, done}, 0);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check("R10 done", {31'd0, done}, 0);
    check("R10 mem_rd", {31'd0, mem_rd}, 0);
    check("R10 pc_out", {16'd0, pc_out}, 0);
    rst_n = 1;
    run("R1 eq pass", 2'd0, 16'h1234, 16'h1234, 16'h0040, 16'h0000, 0);
    run("R1 eq skip", 2'd0, 16'h1234, 16'h1235, 16'h0040, 16'h0001, 0);
    run("R2 ne pass", 2'd1, 16'd1, 16'd2, 16'h0010, 16'h7C02, 0);
    run("R2 ne skip", 2'd1, 16'd7, 16'd7, 16'h0010, 16'h7C02, 0);
    run("R3 gt pass", 2'd2, 16'd2, 16'd1, 16'h0000, 16'h7C02, 0);
    run("R3 gt equal skip R5", 2'd2, 16'd1, 16'd1, 16'h0000, 16'h7C02, 0);
    run("R3 gt unsigned", 2'd2, 16'h8000, 16'h7FFF, 16'h0005, 16'h0000, 0);
    run("R4 bit pass", 2'd3, 16'd3, 16'd1, 16'h0100, 16'hFFFF, 0);
    run("R4 bit skip", 2'd3, 16'd4, 16'd2, 16'h0100, 16'h7DE1, 0);
    run("R5 two extra", 2'd0, 16'd0, 16'd1, 16'h0200, 16'h7DF1, 0);
    run("R5 code 0x17/0x1E", 2'd0, 16'd0, 16'd1, 16'h0200, 16'h7970, 0);
    run("R5 code 0x18/0x0F", 2'd0, 16'd0, 16'd1, 16'h0200, 16'h60F0, 0);
    run("R6 wrap", 2'd0, 16'd0, 16'd1, 16'hFFFF, 16'h7DF1, 0);
    run("R9 busy start", 2'd0, 16'd0, 16'd1, 16'h0300, 16'h7C02, 1);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = ($urandom % 4 == 0) ? a : 16'($urandom);
      run("R1-4 random", 2'($urandom), a, b, 16'($urandom), 16'($urandom), 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule